// File: doc/BRIEF.md
# Luma brightness offset and soft-knee limiter

The block is one stage of a luminance path. It takes one 8-bit luma sample per clock with a valid strobe. It removes the black level from the sample and scales the remainder by a contrast gain in steps of 1/32. It then adds a signed brightness offset and forces any negative result to zero. The value that results is the limiter input.

The limiter input passes through two cascaded soft knees and then a hard ceiling. Each knee leaves the signal untouched up to its own tilt point. Above that point it takes away a programmable number of sixteenths of the excess, and that excess is always measured on the limiter input. When both knees are active and their slopes add up to more than sixteen, the output falls as the input rises. A result that drops below zero is held at zero. The hard ceiling is programmable between 256 and 511.

All limiter arithmetic runs in quarter units, which gives two bits below the integer scale. The control inputs are copied into shadow registers only on cycles without valid data, so each sample sees one consistent set of controls.

Top module: `luma_limiter`

## Requirements
- R1: The limiter input in quarter units is xq = floor((Y - black) * contrast / 8) + 4 * brightness, where brightness is an 8-bit two's-complement value. With both tilts at 511, both slopes 0, hard code 255, Y = 235, black = 16, contrast = 63 and brightness = 20, the output is 451.
- R2: When the offset sum xq is negative (Y below black, or a negative brightness), it is forced to 0, so the output is 0. xq saturates at 4095.
- R3: Knee 1 subtracts r1 = floor(slope1 * max(xq - 4*tilt1, 0) / 16) from xq. With tilt 9-bit and slope 4-bit, an input at or below the tilt is not reduced.
- R4: Knee 2 subtracts r2 = floor(slope2 * max(xq - 4*tilt2, 0) / 16), with its excess also taken from xq. The integer output is floor(max(xq - r1 - r2, 0) / 4), so a slope sum above 16 gives a falling output, and a result below zero gives 0.
- R5: The output never exceeds 256 + hard code, where the hard code is the 8-bit input hard_lim_i.
- R6: valid_o and luma_o follow the valid sample that entered exactly 3 clock edges earlier, in order. No output appears without an input.
- R7: The control inputs are taken into use only on clock edges where valid_i is low. A change made while valid_i is high has no effect on the output until a cycle with valid_i low has passed.
- R8: While rst_ni is low, valid_o and luma_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input sample valid |
| luma_i | input | 8 | Input luma sample |
| black_i | input | 8 | Black level subtracted from the sample |
| contrast_i | input | 6 | Contrast gain in 1/32 steps |
| bright_i | input | 8 | Signed brightness offset |
| tilt1_i | input | 9 | Knee 1 tilt point |
| tilt2_i | input | 9 | Knee 2 tilt point |
| slope1_i | input | 4 | Knee 1 reduction in sixteenths |
| slope2_i | input | 4 | Knee 2 reduction in sixteenths |
| hard_lim_i | input | 8 | Hard ceiling code, ceiling = 256 + code |
| valid_o | output | 1 | Output sample valid |
| luma_o | output | 9 | Limited luma sample |

## Verification
On every cycle the assertions check four things: the 3-edge delay of the valid strobe, the ceiling against the pipelined hard code, that a knee gives no reduction at or below its tilt and never removes more than the signal holds, and that the shadow controls stay fixed while valid data is present. The exact arithmetic can only be shown by the bench scenarios, which compare outputs against an independent model. These cover the worked example, negative clamping, each knee alone, the falling-slope case and the clamp to zero when the slopes combine, and a control change made in the middle of a burst.

// File: rtl/luma_lim_pkg.sv
package luma_lim_pkg;
  localparam int unsigned FRAC_W    = 2;  // extra LSBs below integer scale
  localparam int unsigned CTR_SHIFT = 5;  // contrast is in 1/32 steps
endpackage

// File: rtl/luma_front.sv
module luma_front
  import luma_lim_pkg::*;
#(
  parameter int unsigned Y_W   = 8,
  parameter int unsigned CTR_W = 6,
  parameter int unsigned BRT_W = 8,
  parameter int unsigned XQ_W  = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [Y_W-1:0]   luma_i,
  input  logic [Y_W-1:0]   black_i,
  input  logic [CTR_W-1:0] contrast_i,
  input  logic [BRT_W-1:0] bright_i,
  output logic [XQ_W-1:0]  xq_o
);
  localparam int unsigned DW = Y_W + 1;
  localparam int unsigned PW = DW + CTR_W + 1;
  localparam int unsigned SW = PW + 2;
  localparam logic signed [SW-1:0] XQ_MAX = SW'((1 << XQ_W) - 1);

  logic signed [DW-1:0] diff;
  logic signed [PW-1:0] prod;
  logic signed [SW-1:0] sum;
  logic [XQ_W-1:0]      xq_n;

  always_comb begin
    diff = $signed({1'b0, luma_i}) - $signed({1'b0, black_i});
    prod = PW'(diff) * $signed({1'b0, contrast_i});
    sum  = SW'(prod >>> (CTR_SHIFT - FRAC_W))
         + (SW'($signed(bright_i)) <<< FRAC_W);
    if (sum < 0)            xq_n = '0;
    else if (sum > XQ_MAX)  xq_n = XQ_MAX[XQ_W-1:0];
    else                    xq_n = sum[XQ_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) xq_o <= '0;
    else         xq_o <= xq_n;
endmodule

// File: rtl/luma_knee.sv
module luma_knee
  import luma_lim_pkg::*;
#(
  parameter int unsigned XQ_W   = 12,
  parameter int unsigned TILT_W = 9,
  parameter int unsigned SLP_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [XQ_W-1:0]   xq_i,
  input  logic [TILT_W-1:0] tilt_i,
  input  logic [SLP_W-1:0]  slope_i,
  output logic [XQ_W-1:0]   red_o
);
  localparam int unsigned PW = XQ_W + SLP_W;

  logic [XQ_W-1:0] tq, excess;
  logic [PW-1:0]   prod;

  always_comb begin
    tq     = XQ_W'({tilt_i, {FRAC_W{1'b0}}});
    excess = (xq_i > tq) ? xq_i - tq : '0;
    prod   = PW'(slope_i) * PW'(excess);
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) red_o <= '0;
    else         red_o <= XQ_W'(prod >> SLP_W);
endmodule

// File: rtl/luma_clip.sv
module luma_clip
  import luma_lim_pkg::*;
#(
  parameter int unsigned XQ_W   = 12,
  parameter int unsigned X_W    = 10,
  parameter int unsigned HARD_W = 8,
  parameter int unsigned OUT_W  = HARD_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [XQ_W-1:0]   xq_i,
  input  logic [XQ_W-1:0]   red_a_i,
  input  logic [XQ_W-1:0]   red_b_i,
  input  logic [HARD_W-1:0] hard_i,
  output logic [OUT_W-1:0]  luma_o
);
  localparam int unsigned DW = XQ_W + 2;

  logic signed [DW-1:0] diff;
  logic [DW-1:0]        pos;
  logic [X_W-1:0]       whole;
  logic [OUT_W-1:0]     ceil_v, out_n;

  always_comb begin
    diff   = $signed(DW'(xq_i)) - $signed(DW'(red_a_i)) - $signed(DW'(red_b_i));
    pos    = (diff < 0) ? '0 : diff;
    whole  = X_W'(pos >> FRAC_W);
    ceil_v = {1'b1, hard_i};
    out_n  = (whole > X_W'(ceil_v)) ? ceil_v : OUT_W'(whole);
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) luma_o <= '0;
    else         luma_o <= out_n;
endmodule

// File: rtl/luma_limiter.sv
module luma_limiter
  import luma_lim_pkg::*;
#(
  parameter int unsigned Y_W    = 8,
  parameter int unsigned CTR_W  = 6,
  parameter int unsigned BRT_W  = 8,
  parameter int unsigned TILT_W = 9,
  parameter int unsigned SLP_W  = 4,
  parameter int unsigned HARD_W = 8,
  parameter int unsigned X_W    = 10,
  localparam int unsigned XQ_W  = X_W + FRAC_W,
  localparam int unsigned OUT_W = HARD_W + 1,
  localparam int unsigned N_KNEE = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [Y_W-1:0]    luma_i,
  input  logic [Y_W-1:0]    black_i,
  input  logic [CTR_W-1:0]  contrast_i,
  input  logic [BRT_W-1:0]  bright_i,
  input  logic [TILT_W-1:0] tilt1_i,
  input  logic [TILT_W-1:0] tilt2_i,
  input  logic [SLP_W-1:0]  slope1_i,
  input  logic [SLP_W-1:0]  slope2_i,
  input  logic [HARD_W-1:0] hard_lim_i,
  output logic              valid_o,
  output logic [OUT_W-1:0]  luma_o
);
  // shadow controls, refreshed only between valid samples
  logic [Y_W-1:0]    black_q;
  logic [CTR_W-1:0]  contrast_q;
  logic [BRT_W-1:0]  bright_q;
  logic [TILT_W-1:0] tilt_q  [N_KNEE];
  logic [SLP_W-1:0]  slope_q [N_KNEE];
  logic [HARD_W-1:0] hard_q;

  logic [TILT_W-1:0] tilt_in  [N_KNEE];
  logic [SLP_W-1:0]  slope_in [N_KNEE];
  assign tilt_in[0]  = tilt1_i;
  assign tilt_in[1]  = tilt2_i;
  assign slope_in[0] = slope1_i;
  assign slope_in[1] = slope2_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      black_q    <= '0;
      contrast_q <= '0;
      bright_q   <= '0;
      hard_q     <= '0;
    end else if (!valid_i) begin
      black_q    <= black_i;
      contrast_q <= contrast_i;
      bright_q   <= bright_i;
      hard_q     <= hard_lim_i;
    end

  // stage 1: offset sum; controls travel with the sample
  logic              v_s1, v_s2;
  logic [XQ_W-1:0]   xq_s1, xq_s2;
  logic [TILT_W-1:0] tilt_s1  [N_KNEE];
  logic [SLP_W-1:0]  slope_s1 [N_KNEE];
  logic [HARD_W-1:0] hard_s1, hard_s2;
  logic [XQ_W-1:0]   red_s2   [N_KNEE];

  luma_front #(.Y_W(Y_W), .CTR_W(CTR_W), .BRT_W(BRT_W), .XQ_W(XQ_W)) i_front (
    .clk_i, .rst_ni,
    .luma_i, .black_i(black_q), .contrast_i(contrast_q), .bright_i(bright_q),
    .xq_o(xq_s1)
  );

  for (genvar k = 0; k < N_KNEE; k++) begin : g_knee
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) begin
        tilt_q[k]   <= '0;
        slope_q[k]  <= '0;
        tilt_s1[k]  <= '0;
        slope_s1[k] <= '0;
      end else begin
        if (!valid_i) begin
          tilt_q[k]  <= tilt_in[k];
          slope_q[k] <= slope_in[k];
        end
        tilt_s1[k]  <= tilt_q[k];
        slope_s1[k] <= slope_q[k];
      end

    // stage 2: knee reduction, both knees see the same limiter input
    luma_knee #(.XQ_W(XQ_W), .TILT_W(TILT_W), .SLP_W(SLP_W)) i_knee (
      .clk_i, .rst_ni,
      .xq_i(xq_s1), .tilt_i(tilt_s1[k]), .slope_i(slope_s1[k]),
      .red_o(red_s2[k])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      v_s1    <= 1'b0;
      v_s2    <= 1'b0;
      valid_o <= 1'b0;
      hard_s1 <= '0;
      hard_s2 <= '0;
      xq_s2   <= '0;
    end else begin
      v_s1    <= valid_i;
      v_s2    <= v_s1;
      valid_o <= v_s2;
      hard_s1 <= hard_q;
      hard_s2 <= hard_s1;
      xq_s2   <= xq_s1;
    end

  // stage 3: subtract, clamp, hard ceiling
  luma_clip #(.XQ_W(XQ_W), .X_W(X_W), .HARD_W(HARD_W), .OUT_W(OUT_W)) i_clip (
    .clk_i, .rst_ni,
    .xq_i(xq_s2), .red_a_i(red_s2[0]), .red_b_i(red_s2[1]), .hard_i(hard_s2),
    .luma_o
  );
endmodule

// File: rtl/luma_limiter_chk.sv
module luma_limiter_chk #(
  parameter int unsigned XQ_W   = 12,
  parameter int unsigned TILT_W = 9,
  parameter int unsigned HARD_W = 8,
  parameter int unsigned OUT_W  = 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic              valid_o,
  input logic [OUT_W-1:0]  luma_o,
  input logic              v_s1,
  input logic [XQ_W-1:0]   xq_s1,
  input logic [XQ_W-1:0]   xq_s2,
  input logic [TILT_W-1:0] tilt1_s1,
  input logic [XQ_W-1:0]   red1_s2,
  input logic [XQ_W-1:0]   red2_s2,
  input logic [HARD_W-1:0] hard_s2,
  input logic [HARD_W-1:0] hard_q,
  input logic [TILT_W-1:0] tilt1_q
);
  logic [1:0] since_rst;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)              since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;

  p_latency_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == 2'd3) |-> (valid_o == $past(valid_i, 3)));

  p_ceiling_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (luma_o <= {1'b1, hard_s2}));

  p_knee_flat_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v_s1 && (xq_s1 <= XQ_W'({tilt1_s1, 2'b00}))) |=> (red1_s2 == '0));

  p_reduce_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (red1_s2 <= xq_s2) && (red2_s2 <= xq_s2));

  p_shadow_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> ($stable(hard_q) && $stable(tilt1_q)));
endmodule

bind luma_limiter luma_limiter_chk #(
  .XQ_W(XQ_W), .TILT_W(TILT_W), .HARD_W(HARD_W), .OUT_W(OUT_W)
) i_chk (
  .clk_i, .rst_ni, .valid_i, .valid_o, .luma_o,
  .v_s1, .xq_s1, .xq_s2,
  .tilt1_s1(tilt_s1[0]),
  .red1_s2(red_s2[0]), .red2_s2(red_s2[1]),
  .hard_s2, .hard_q,
  .tilt1_q(tilt_q[0])
);

// File: tb/test_luma_limiter.sv
`timescale 1ns/1ps
module test_luma_limiter;
  typedef struct {
    int blk, con, br, t1, t2, s1, s2, hc;
  } cfg_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid_i = 1'b0;
  logic [7:0] luma_i = '0, black_i = '0, bright_i = '0, hard_i = '0;
  logic [5:0] contrast_i = '0;
  logic [8:0] tilt1_i = '0, tilt2_i = '0;
  logic [3:0] slope1_i = '0, slope2_i = '0;
  logic       valid_o;
  logic [8:0] luma_o;

  always #4 clk = ~clk;

  luma_limiter i_luma_limiter (
    .clk_i(clk), .rst_ni(rst_n), .valid_i, .luma_i, .black_i, .contrast_i,
    .bright_i, .tilt1_i, .tilt2_i, .slope1_i, .slope2_i, .hard_lim_i(hard_i),
    .valid_o, .luma_o
  );

  int    total = 0, fails = 0, cyc = 0;
  bit    done = 1'b0;
  cfg_t  cur;
  int    exp_q[$];
  int    cyc_q[$];
  string tag_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int model(cfg_t c, int y);
    int xq, e1, e2, r1, r2, o;
    xq = ((y - c.blk) * c.con) >>> 3;
    xq = xq + 4 * c.br;
    if (xq < 0) xq = 0;
    if (xq > 4095) xq = 4095;
    e1 = xq - 4 * c.t1; if (e1 < 0) e1 = 0;
    e2 = xq - 4 * c.t2; if (e2 < 0) e2 = 0;
    r1 = (c.s1 * e1) >>> 4;
    r2 = (c.s2 * e2) >>> 4;
    o = xq - r1 - r2;
    if (o < 0) o = 0;
    o = o >>> 2;
    if (o > 256 + c.hc) o = 256 + c.hc;
    return o;
  endfunction

  task automatic drive_cfg(cfg_t c);
    black_i = 8'(c.blk); contrast_i = 6'(c.con); bright_i = 8'(c.br);
    tilt1_i = 9'(c.t1); tilt2_i = 9'(c.t2);
    slope1_i = 4'(c.s1); slope2_i = 4'(c.s2); hard_i = 8'(c.hc);
  endtask

  task automatic apply(cfg_t c);
    @(negedge clk);
    valid_i = 1'b0;
    drive_cfg(c);
    cur = c;
  endtask

  task automatic send(int y, string tag);
    @(negedge clk);
    luma_i  = 8'(y);
    valid_i = 1'b1;
    exp_q.push_back(model(cur, y));
    cyc_q.push_back(cyc);
    tag_q.push_back(tag);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid_i = 1'b0;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && valid_o && !done) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R6 unexpected output", int'(luma_o), -1);
      end else begin
        int e, c0;
        string t;
        e = exp_q.pop_front(); c0 = cyc_q.pop_front(); t = tag_q.pop_front();
        chk(int'(luma_o) == e, t, int'(luma_o), e);
        chk(cyc - c0 == 3, "R6 latency", cyc - c0, 3);
      end
    end
  end

  task automatic finish_up();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    chk(1'b0, "watchdog", cyc, 0);
    finish_up();
  end

  initial begin
    cfg_t base, c;
    base = '{blk:16, con:63, br:20, t1:511, t2:511, s1:0, s2:0, hc:255};
    cur = base;
    drive_cfg(base);
    valid_i = 1'b1; luma_i = 8'd200;
    repeat (3) @(negedge clk);
    // R8: outputs held at zero in reset even with valid_i high
    chk(valid_o == 1'b0, "R8 valid in reset", int'(valid_o), 0);
    chk(luma_o == '0, "R8 luma in reset", int'(luma_o), 0);
    valid_i = 1'b0;
    @(negedge clk); rst_n = 1'b1;

    // R1: worked example and plain offsets
    apply(base);
    send(235, "R1 example 451");
    chk(model(base, 235) == 451, "R1 model example", model(base, 235), 451);
    send(16, "R1 black in");
    send(100, "R1 mid");
    send(255, "R1 top");

    // R2: negative clamp
    c = base; c.br = -50; apply(c);
    send(20, "R2 negative brightness");
    send(120, "R2 partly offset");
    c = base; c.br = 0; apply(c);
    send(10, "R2 below black");
    send(0, "R2 zero in");

    // R3: knee 1 only
    c = base; c.t1 = 200; c.s1 = 8; apply(c);
    send(235, "R3 above tilt1");
    send(100, "R3 below tilt1");
    c.s1 = 15; apply(c);
    send(235, "R3 slope 15");
    send(200, "R3 slope 15 mid");

    // R4: both knees, slope sum above 16
    c = base; c.t1 = 200; c.s1 = 12; c.t2 = 300; c.s2 = 10; apply(c);
    for (int y = 150; y <= 255; y += 15) send(y, "R4 falling region");
    c = base; c.t1 = 0; c.t2 = 0; c.s1 = 15; c.s2 = 15; apply(c);
    send(200, "R4 clamp to zero");
    c.s2 = 1; apply(c);
    send(200, "R4 slope sum 16");

    // R5: hard ceiling
    c = base; c.hc = 0; apply(c);
    send(235, "R5 ceiling 256");
    c.hc = 100; apply(c);
    send(235, "R5 ceiling 356");
    send(50, "R5 below ceiling");

    // R7: control change during a burst is ignored until a gap
    c = base; apply(c);
    send(235, "R7 before change");
    c.hc = 0; c.br = 0;
    drive_cfg(c);
    send(235, "R7 change held off");
    send(200, "R7 change held off");
    idle(1);
    cur = c;
    send(235, "R7 change applied");

    // mixed sweep, back to back
    for (int k = 0; k < 4; k++) begin
      c = '{blk:16 + 4*k, con:32 + 10*k, br:-30 + 25*k, t1:150 + 40*k,
            t2:260 + 30*k, s1:3 + 4*k, s2:14 - 3*k, hc:40*k};
      apply(c);
      for (int y = 0; y < 256; y += 37) send(y, "R4 sweep");
    end

    idle(8);
    chk(exp_q.size() == 0, "R6 all outputs seen", exp_q.size(), 0);
    chk(valid_o == 1'b0, "R6 idle valid", int'(valid_o), 0);
    finish_up();
  end
endmodule